// File: doc/BRIEF.md
# Strap-Selected Boot Source Sequencer

After every reset this controller captures three strap inputs and one override request, and chooses an ordered list of boot media from them. It then works through the list one medium at a time. For each try it raises a one-hot request to an external loader. It waits for a done pulse carrying pass or fail, or for its own per-try timer to run out. A pass ends the sequence with the chosen medium reported. A fail or a timeout moves on to the next medium. When the list is used up, an exhausted flag is raised and the block stays quiet until the next reset.

An override request can put USB, SD or SPI-NOR in front of the strap order, and the full strap order still follows it. A USB override also sets a sticky flag. That flag is held through a warm reset, and while it is set USB goes first on every later boot. Only the cold (power-on) reset clears it.

The states are ST_LATCH, ST_ATTEMPT, ST_ADVANCE, ST_BOOTED and ST_EXHAUSTED. Their transitions are:
- LATCH to ATTEMPT: the inputs are captured on the first clock after reset.
- ATTEMPT to BOOTED: a pass result arrives.
- ATTEMPT to ADVANCE: a fail result arrives, or the timer expires.
- ADVANCE to ATTEMPT: more steps remain.
- ADVANCE to EXHAUSTED: the last step has failed.

BOOTED and EXHAUSTED are terminal.

Top module: `boot_seq_ctrl`

## Requirements
- R1: `strap_i`, `ovr_valid_i` and `ovr_src_i` are captured on the first rising clock edge after both resets are high. Later changes to them have no effect until the next reset.
- R2: The strap bits are mapped as strap_i[0]=S0, strap_i[1]=S1, strap_i[2]=S2. The orders are:
  - S1=0, S2=0: USB, SPI-NOR, NAND/eMMC, SD.
  - S1=0, S2=1: USB, NAND/eMMC, SD.
  - S1=1, S2=0: SPI-NOR, NAND/eMMC, SD, USB.
  - S1=1, S2=1, S0=1: NAND/eMMC, SD, USB.
  - S1=1, S2=1, S0=0: SPI-NAND, NAND/eMMC, USB.
- R3: The medium codes are USB=0, SPI-NOR=1, NAND/eMMC=2, SD=3 and SPI-NAND=4. During a try, `ld_req_o` has exactly bit (code) set. Between tries it is zero for at least one cycle.
- R4: A `ld_done_i` pulse with `ld_pass_i`=0 ends the try and starts the next one. With `ld_pass_i`=1 the block moves to booted: `boot_ok_o`=1 and `boot_src_o` holds the code of that medium.
- R5: If no result arrives, a try lasts exactly `tmo_limit_i`+1 cycles and is then treated as a fail.
- R6: After the last step fails, `exhausted_o` rises and no further request is made until reset.
- R7: A valid override with `ovr_src_i` 00 (USB), 01 (SD) or 10 (SPI-NOR) puts that medium first, followed by the full strap order. The code 11 is ignored.
- R8: `usb_forced_o` is set when USB is put first by override. It stays set through warm reset (`rst_n` low) and then forces USB first. It is cleared only by `por_n` low.
- R9: When a result and the timer expiry fall in the same cycle, the result wins.
- R10: `boot_ok_o` and `exhausted_o` are never both high. Both states, and `boot_src_o`, hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold reset, active low, clears everything |
| rst_n | input | 1 | Warm reset, active low, keeps the sticky USB flag |
| strap_i | input | 3 | Strap bits S0..S2 |
| ovr_valid_i | input | 1 | Override request present |
| ovr_src_i | input | 2 | Override medium: 00 USB, 01 SD, 10 SPI-NOR, 11 none |
| tmo_limit_i | input | TMO_W | Per-try timeout limit |
| ld_done_i | input | 1 | Loader result pulse |
| ld_pass_i | input | 1 | Loader result: 1 pass, 0 fail |
| ld_req_o | output | 5 | One-hot request for the current medium |
| boot_ok_o | output | 1 | Boot succeeded |
| boot_src_o | output | 3 | Code of the medium that succeeded |
| exhausted_o | output | 1 | All steps failed |
| usb_forced_o | output | 1 | Sticky forced-USB flag |

## Verification
A loader result and the expiry of the try timer can land in the same clock cycle. The bench provokes this by answering a try with a pass exactly `tmo_limit_i` cycles after it sees the request. It then judges the outcome: the block must report booted on that medium, not move on to the next step.

In the same way, a fail result on the last step leads straight to the exhausted state with no extra request. Timeout-only tries are also timed from the ports to confirm their length.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
    localparam int MEDIA_N         = 5;
    localparam int MED_W           = 3;
    localparam int MAX_STRAP_STEPS = 4;
    localparam int MAX_STEPS       = MAX_STRAP_STEPS + 1;
    localparam int STEP_W          = $clog2(MAX_STEPS + 1);
    localparam int IDX_W           = $clog2(MAX_STRAP_STEPS);

    typedef enum logic [MED_W-1:0] {
        MED_USB     = 3'd0,
        MED_SPINOR  = 3'd1,
        MED_EMMC    = 3'd2,
        MED_SD      = 3'd3,
        MED_SPINAND = 3'd4
    } medium_e;

    typedef enum logic [2:0] {
        ST_LATCH,
        ST_ATTEMPT,
        ST_ADVANCE,
        ST_BOOTED,
        ST_EXHAUSTED
    } seq_state_e;
endpackage

// File: rtl/boot_order_map.sv
module boot_order_map
    import boot_seq_pkg::*;
(
    input  logic [2:0]        strap_i,
    input  logic              forced_i,
    input  medium_e           forced_med_i,
    input  logic [STEP_W-1:0] step_i,
    output medium_e           medium_o,
    output logic              last_o
);
    medium_e           base [MAX_STRAP_STEPS];
    logic [STEP_W-1:0] base_len;
    logic [STEP_W-1:0] sidx;

    always_comb begin
        base[0]  = MED_EMMC;
        base[1]  = MED_SD;
        base[2]  = MED_USB;
        base[3]  = MED_USB;
        base_len = STEP_W'(3);
        unique case ({strap_i[1], strap_i[2]})
            2'b00: begin
                base[0]  = MED_USB;
                base[1]  = MED_SPINOR;
                base[2]  = MED_EMMC;
                base[3]  = MED_SD;
                base_len = STEP_W'(4);
            end
            2'b01: begin
                base[0]  = MED_USB;
                base[1]  = MED_EMMC;
                base[2]  = MED_SD;
            end
            2'b10: begin
                base[0]  = MED_SPINOR;
                base[1]  = MED_EMMC;
                base[2]  = MED_SD;
                base[3]  = MED_USB;
                base_len = STEP_W'(4);
            end
            default: begin
                if (!strap_i[0]) begin
                    base[0] = MED_SPINAND;
                    base[1] = MED_EMMC;
                    base[2] = MED_USB;
                end
            end
        endcase
    end

    always_comb begin
        if (forced_i) begin
            sidx   = step_i - STEP_W'(1);
            last_o = (step_i == base_len);
            if (step_i == '0) begin
                medium_o = forced_med_i;
            end else begin
                medium_o = base[sidx[IDX_W-1:0]];
            end
        end else begin
            sidx     = step_i;
            last_o   = (step_i == base_len - STEP_W'(1));
            medium_o = base[sidx[IDX_W-1:0]];
        end
    end
endmodule

// File: rtl/boot_try_timer.sv
module boot_try_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != limit_i) begin
            cnt_q <= cnt_q + TMO_W'(1);
        end
    end

    assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/boot_usb_sticky.sv
module boot_usb_sticky (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end
    end
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
    import boot_seq_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_n,
    input  logic [2:0]         strap_i,
    input  logic               ovr_valid_i,
    input  logic [1:0]         ovr_src_i,
    input  logic [TMO_W-1:0]   tmo_limit_i,
    input  logic               ld_done_i,
    input  logic               ld_pass_i,
    output logic [MEDIA_N-1:0] ld_req_o,
    output logic               boot_ok_o,
    output logic [MED_W-1:0]   boot_src_o,
    output logic               exhausted_o,
    output logic               usb_forced_o
);
    logic              sys_rst_n;
    seq_state_e        state_q, state_d;
    logic [2:0]        strap_q;
    logic              forced_q;
    medium_e           fmed_q;
    logic [STEP_W-1:0] step_q;
    medium_e           cur_med;
    logic              last_step;
    logic              expired;
    logic              sticky_q;
    logic              lat_forced;
    medium_e           lat_med;

    assign sys_rst_n = por_n & rst_n;

    // Forced-first selection at capture time: sticky USB beats the override.
    always_comb begin
        lat_forced = 1'b0;
        lat_med    = MED_USB;
        if (sticky_q) begin
            lat_forced = 1'b1;
        end else if (ovr_valid_i) begin
            unique case (ovr_src_i)
                2'b00:   begin lat_forced = 1'b1; lat_med = MED_USB;    end
                2'b01:   begin lat_forced = 1'b1; lat_med = MED_SD;     end
                2'b10:   begin lat_forced = 1'b1; lat_med = MED_SPINOR; end
                default: lat_forced = 1'b0;
            endcase
        end
    end

    boot_usb_sticky u_sticky (
        .clk    (clk),
        .por_n  (por_n),
        .set_i  ((state_q == ST_LATCH) && lat_forced && (lat_med == MED_USB)),
        .flag_o (sticky_q)
    );

    boot_order_map u_map (
        .strap_i      (strap_q),
        .forced_i     (forced_q),
        .forced_med_i (fmed_q),
        .step_i       (step_q),
        .medium_o     (cur_med),
        .last_o       (last_step)
    );

    boot_try_timer #(.TMO_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .run_i     (state_q == ST_ATTEMPT),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LATCH:   state_d = ST_ATTEMPT;
            ST_ATTEMPT: begin
                if (ld_done_i) begin
                    state_d = ld_pass_i ? ST_BOOTED : ST_ADVANCE;
                end else if (expired) begin
                    state_d = ST_ADVANCE;
                end
            end
            ST_ADVANCE: state_d = last_step ? ST_EXHAUSTED : ST_ATTEMPT;
            ST_BOOTED:    state_d = ST_BOOTED;
            ST_EXHAUSTED: state_d = ST_EXHAUSTED;
            default:      state_d = ST_LATCH;
        endcase
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            state_q  <= ST_LATCH;
            strap_q  <= '0;
            forced_q <= 1'b0;
            fmed_q   <= MED_USB;
            step_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LATCH) begin
                strap_q  <= strap_i;
                forced_q <= lat_forced;
                fmed_q   <= lat_med;
                step_q   <= '0;
            end else if (state_q == ST_ADVANCE && !last_step) begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    always_comb begin
        ld_req_o     = '0;
        boot_ok_o    = 1'b0;
        boot_src_o   = '0;
        exhausted_o  = 1'b0;
        usb_forced_o = sticky_q;
        unique case (state_q)
            ST_ATTEMPT:   ld_req_o = {{(MEDIA_N-1){1'b0}}, 1'b1} << cur_med;
            ST_BOOTED: begin
                boot_ok_o  = 1'b1;
                boot_src_o = cur_med;
            end
            ST_EXHAUSTED: exhausted_o = 1'b1;
            default:      ld_req_o = '0;
        endcase
    end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
    import boot_seq_pkg::*;
(
    input logic               clk,
    input logic               por_n,
    input logic               rst_n,
    input logic               ld_done_i,
    input logic               ld_pass_i,
    input logic [MEDIA_N-1:0] ld_req_o,
    input logic               boot_ok_o,
    input logic [MED_W-1:0]   boot_src_o,
    input logic               exhausted_o,
    input logic               usb_forced_o
);
    // R3: at most one medium requested at a time
    p_req_onehot_r3: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        $onehot0(ld_req_o));

    // R4: a fail result drops the request for at least one cycle
    p_fail_gap_r4: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (ld_req_o != '0 && ld_done_i && !ld_pass_i) |=> (ld_req_o == '0));

    // R4: a pass result reports the requested medium
    p_pass_src_r4: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        (ld_req_o != '0 && ld_done_i && ld_pass_i) |=>
            (boot_ok_o && (({{(MEDIA_N-1){1'b0}}, 1'b1} << boot_src_o) == $past(ld_req_o))));

    // R6: exhaustion is terminal and silent
    p_exh_hold_r6: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        exhausted_o |=> (exhausted_o && ld_req_o == '0));

    // R8: sticky flag is not cleared by warm reset
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
        usb_forced_o |=> usb_forced_o);

    // R10: terminal states exclusive and stable
    p_ok_excl_r10: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        !(boot_ok_o && exhausted_o));
    p_ok_hold_r10: assert property (@(posedge clk) disable iff (!(por_n && rst_n))
        boot_ok_o |=> (boot_ok_o && $stable(boot_src_o) && ld_req_o == '0));
endmodule

bind boot_seq_ctrl boot_seq_chk u_boot_seq_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .ld_done_i    (ld_done_i),
    .ld_pass_i    (ld_pass_i),
    .ld_req_o     (ld_req_o),
    .boot_ok_o    (boot_ok_o),
    .boot_src_o   (boot_src_o),
    .exhausted_o  (exhausted_o),
    .usb_forced_o (usb_forced_o)
);

// File: tb/test_boot_seq_ctrl.sv
`timescale 1ns/1ps
module test_boot_seq_ctrl;
    localparam int TMO_W = 16;
    localparam int LIM   = 6;
    localparam logic [2:0] USB = 3'd0, NOR = 3'd1, EMMC = 3'd2, SD = 3'd3, SNAND = 3'd4;

    typedef enum int {A_FAIL, A_PASS, A_TMO} act_e;
    typedef struct {
        logic [2:0] med;
        act_e       act;
        int         dly;
    } item_t;

    logic             clk = 1'b0;
    logic             por_n = 1'b0, rst_n = 1'b0;
    logic [2:0]       strap_i = 3'b000;
    logic             ovr_valid_i = 1'b0;
    logic [1:0]       ovr_src_i = 2'b11;
    logic [TMO_W-1:0] tmo_limit_i = TMO_W'(LIM);
    logic             ld_done_i = 1'b0, ld_pass_i = 1'b0;
    logic [4:0]       ld_req_o;
    logic             boot_ok_o, exhausted_o, usb_forced_o;
    logic [2:0]       boot_src_o;

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R2";
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    boot_seq_ctrl #(.TMO_W(TMO_W)) i_boot_seq_ctrl (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_i(strap_i),
        .ovr_valid_i(ovr_valid_i), .ovr_src_i(ovr_src_i), .tmo_limit_i(tmo_limit_i),
        .ld_done_i(ld_done_i), .ld_pass_i(ld_pass_i), .ld_req_o(ld_req_o),
        .boot_ok_o(boot_ok_o), .boot_src_o(boot_src_o), .exhausted_o(exhausted_o),
        .usb_forced_o(usb_forced_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic push(input logic [2:0] med, input act_e act, input int dly);
        item_t it;
        it.med = med; it.act = act; it.dly = dly;
        exp_q.push_back(it);
    endtask

    // Monitor / responder: pops the expected medium on each new request
    initial begin
        forever begin
            @(negedge clk);
            if (ld_req_o != '0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected request", int'(ld_req_o), 0);
                end else begin
                    item_t it;
                    int    hi;
                    it = exp_q.pop_front();
                    chk(ld_req_o == (5'd1 << it.med), {tag, "/R3 request"},
                        int'(ld_req_o), int'(5'd1 << it.med));
                    if (it.act == A_TMO) begin
                        hi = 0;
                        while (ld_req_o != '0) begin
                            hi++;
                            @(negedge clk);
                        end
                        chk(hi == LIM + 1, "R5 try length", hi, LIM + 1);
                    end else begin
                        repeat (it.dly) @(negedge clk);
                        ld_done_i = 1'b1;
                        ld_pass_i = (it.act == A_PASS);
                        @(negedge clk);
                        ld_done_i = 1'b0;
                        ld_pass_i = 1'b0;
                    end
                end
                while (ld_req_o != '0) @(negedge clk);
            end
        end
    end

    task automatic do_reset(input bit cold);
        @(negedge clk);
        if (cold) por_n = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ld_req_o == '0 && !boot_ok_o && !exhausted_o, "R10 reset state",
            int'({ld_req_o, boot_ok_o, exhausted_o}), 0);
    endtask

    task automatic release_and_wait(input bit exp_ok, input logic [2:0] exp_src,
                                    input bit flip_straps);
        int n;
        por_n = 1'b1;
        rst_n = 1'b1;
        if (flip_straps) begin
            repeat (2) @(negedge clk);
            strap_i     = ~strap_i;
            ovr_valid_i = 1'b1;
            ovr_src_i   = 2'b01;
        end
        n = 0;
        while (!(boot_ok_o || exhausted_o) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        chk(boot_ok_o == exp_ok, {tag, "/R4 boot_ok"}, int'(boot_ok_o), int'(exp_ok));
        chk(exhausted_o == !exp_ok, {tag, "/R6 exhausted"}, int'(exhausted_o), int'(!exp_ok));
        if (exp_ok) chk(boot_src_o == exp_src, {tag, "/R4 source"}, int'(boot_src_o), int'(exp_src));
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " steps left"}, exp_q.size(), 0);
        chk(!(boot_ok_o && exhausted_o) && ld_req_o == '0 && boot_ok_o == exp_ok,
            "R10 terminal hold", int'({boot_ok_o, exhausted_o}), int'({exp_ok, !exp_ok}));
        if (exp_ok) chk(boot_src_o == exp_src, "R10 source hold", int'(boot_src_o), int'(exp_src));
        ovr_valid_i = 1'b0;
        ovr_src_i   = 2'b11;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // Case 1: production strap, R2
        tag = "R2"; strap_i = 3'b111;
        do_reset(1'b1);
        chk(usb_forced_o == 1'b0, "R8 cold clear", int'(usb_forced_o), 0);
        push(EMMC, A_FAIL, 1); push(SD, A_FAIL, 0); push(USB, A_PASS, 2);
        release_and_wait(1'b1, USB, 1'b0);

        // Case 2: S0=0,S1=1,S2=1 with a timeout, R5 and R6
        tag = "R6"; strap_i = 3'b110;
        do_reset(1'b1);
        push(SNAND, A_FAIL, 0); push(EMMC, A_TMO, 0); push(USB, A_FAIL, 3);
        release_and_wait(1'b0, 3'd0, 1'b0);

        // Case 3: strap 000, straps flipped after capture, R1
        tag = "R1"; strap_i = 3'b000;
        do_reset(1'b1);
        push(USB, A_FAIL, 0); push(NOR, A_FAIL, 0); push(EMMC, A_FAIL, 1); push(SD, A_PASS, 0);
        release_and_wait(1'b1, SD, 1'b1);

        // Case 4: S0 alone set gives the same order as 000
        tag = "R2"; strap_i = 3'b001;
        do_reset(1'b1);
        push(USB, A_PASS, 0);
        release_and_wait(1'b1, USB, 1'b0);

        // Case 5: S2 alone set, three-step order, all fail
        tag = "R6"; strap_i = 3'b100;
        do_reset(1'b1);
        push(USB, A_FAIL, 0); push(EMMC, A_FAIL, 0); push(SD, A_FAIL, 0);
        release_and_wait(1'b0, 3'd0, 1'b0);

        // Case 6: S1 alone set; pass lands on the timer expiry cycle, R9
        tag = "R9"; strap_i = 3'b010;
        do_reset(1'b1);
        push(NOR, A_PASS, LIM);
        release_and_wait(1'b1, NOR, 1'b0);

        // Case 7: SD override then full order, R7
        tag = "R7"; strap_i = 3'b111; ovr_valid_i = 1'b1; ovr_src_i = 2'b01;
        do_reset(1'b1);
        push(SD, A_FAIL, 0); push(EMMC, A_PASS, 0);
        release_and_wait(1'b1, EMMC, 1'b0);
        chk(usb_forced_o == 1'b0, "R8 no sticky from SD", int'(usb_forced_o), 0);

        // Case 8: override code 11 ignored, R7
        tag = "R7"; strap_i = 3'b111; ovr_valid_i = 1'b1; ovr_src_i = 2'b11;
        do_reset(1'b1);
        push(EMMC, A_PASS, 0);
        release_and_wait(1'b1, EMMC, 1'b0);

        // Case 9: USB override sets sticky flag, R8
        tag = "R8"; strap_i = 3'b111; ovr_valid_i = 1'b1; ovr_src_i = 2'b00;
        do_reset(1'b1);
        push(USB, A_FAIL, 0); push(EMMC, A_FAIL, 0); push(SD, A_PASS, 0);
        release_and_wait(1'b1, SD, 1'b0);
        chk(usb_forced_o == 1'b1, "R8 sticky set", int'(usb_forced_o), 1);

        // Case 10: warm reset keeps USB first, R8
        tag = "R8"; strap_i = 3'b111;
        do_reset(1'b0);
        chk(usb_forced_o == 1'b1, "R8 held in warm reset", int'(usb_forced_o), 1);
        push(USB, A_PASS, 0);
        release_and_wait(1'b1, USB, 1'b0);

        // Case 11: cold reset clears it, R8
        tag = "R8"; strap_i = 3'b111;
        do_reset(1'b1);
        chk(usb_forced_o == 1'b0, "R8 cleared by cold reset", int'(usb_forced_o), 0);
        push(EMMC, A_PASS, 0);
        release_and_wait(1'b1, EMMC, 1'b0);

        // Case 12: SPI-NOR override on a three-step order, four tries then exhausted, R7
        tag = "R7"; strap_i = 3'b100; ovr_valid_i = 1'b1; ovr_src_i = 2'b10;
        do_reset(1'b1);
        push(NOR, A_FAIL, 0); push(USB, A_FAIL, 0); push(EMMC, A_TMO, 0); push(SD, A_FAIL, 0);
        release_and_wait(1'b0, 3'd0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule